// File: doc/BRIEF.md
# Audio Codec Control Register File

This block holds the byte-wide control registers of an audio codec of the AC'97 family. A host writes one byte per cycle to an 8-bit register index, and reads one byte back one cycle after it presents a read index. The write is not a plain store. Each write passes through a per-register filter first:

- Volume bytes are masked and their 6-bit attenuation level is saturated.
- The extended status/control byte keeps only its defined enable bits.
- Variable sample rate registers only take a write while the matching enable bit is set.
- Rate registers are limited to 48000.

Clearing the DAC variable rate enable puts every DAC rate back to 48000.

A side port selects one of the five 16-bit rate registers and reports the rate that is actually in effect. For the three DAC rates, that value is doubled while double rate is enabled. Reset loads the capability, status and codec identification bytes and sets every rate to 48000.

Top module: `acodec_regfile`

## Requirements
- R1: After reset, the bytes read back are: index 0x26 = 0x0F; 0x28 = 0x0B (0x09 when DOUBLE_RATE is 0); 0x29 = CODEC_ID<<6 | 0x02; 0x2A = 0x00; each rate pair 0x2C..0x35 = 48000 (low byte 0x80, high byte 0xBB). Every other index reads 0x00, and rd_data is 0x00 while reset is held.
- R2: A write to 0x02, 0x04 or 0x06 keeps bits [5:0]. If bit 5 of that level is set, the stored level becomes 0x1F.
- R3: A write to 0x03 or 0x05 keeps the bits of mask 0xBF. If bit 5 is then set, bit 5 is cleared and bits [4:0] become 1; bit 7 is kept as written.
- R4: A write to 0x0A keeps only the bits of mask 0x1E.
- R5: A write to 0x2A keeps the bits of mask 0x0B (0x09 when DOUBLE_RATE is 0). Bit 0 enables DAC variable rate, bit 1 enables double rate, and bit 3 enables ADC variable rate.
- R6: A write to 0x2A whose stored bit 0 is 0 sets the DAC rates at 0x2C, 0x2E and 0x30 to 48000 on the same edge. The ADC rates are left unchanged.
- R7: A write to 0x2C..0x31 is ignored unless bit 0 of 0x2A is set. A write to 0x32..0x35 is ignored unless bit 3 of 0x2A is set.
- R8: A write to the odd (high) byte of a rate register stores 48000 in the whole register if {new high byte, stored low byte} exceeds 48000. Otherwise it stores the byte as written. A low-byte write is not limited.
- R9: rate_out shows the rate register selected by rate_sel: 0..2 select the DAC rates at 0x2C, 0x2E, 0x30, and 3..4 select the ADC rates at 0x32, 0x34. A DAC rate is shown doubled while bit 1 of 0x2A is set. ADC rates are never doubled, and rate_sel values 5..7 show 0.
- R10: Writes to the read-only indices 0x00, 0x01, 0x26, 0x28 and 0x29 change nothing.
- R11: Writes to any index not named above store the byte unmodified. rd_data is the byte at rd_idx as it stood before the edge, one cycle after rd_idx is presented, so a read and a write of the same index on the same edge return the old byte.
- R12: Each rate register is little-endian: the low byte is at the even index and the high byte at the odd index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_idx | input | 8 | Register index written |
| wr_data | input | 8 | Byte written |
| rd_idx | input | 8 | Register index read |
| rd_data | output | 8 | Byte read, one cycle after rd_idx |
| rate_sel | input | 3 | Rate register selector for rate_out |
| rate_out | output | 17 | Effective sample rate in Hz |

## Verification
The volume filters are driven with levels below and above 0x20, and with the mute bit and the reserved bit set. This separates the masking from the saturation. Rate registers are written with the enables off, with each enable on alone, and with both on. This shows whether DAC and ADC gating are decoded apart. High-byte writes land just above 48000 and exactly on it, which pins down where the cap applies. A long run of pseudo-random writes and reads over the low 64 indices, checked against the reference model on every cycle, covers the remaining interactions, such as disabling DAC variable rate while ADC variable rate stays enabled.

// File: rtl/acr_pkg.sv
package acr_pkg;

    localparam int IDX_W     = 8;
    localparam int DEPTH     = 1 << IDX_W;
    localparam int NUM_RATES = 5;
    localparam int NUM_DAC   = 3;
    localparam int SEL_W     = $clog2(NUM_RATES);
    localparam int RATE_OUT_W = 17;

    localparam logic [15:0] RATE_MAX = 16'd48000;

    localparam logic [7:0] IX_CTL      = 8'h2A;
    localparam logic [7:0] IX_RATE_LO  = 8'h2C;
    localparam logic [7:0] IX_ADC_LO   = 8'h32;
    localparam logic [7:0] IX_RATE_HI  = 8'h35;
    localparam logic [7:0] IX_STATUS   = 8'h26;
    localparam logic [7:0] IX_EXT_ID   = 8'h28;
    localparam logic [7:0] IX_EXT_ID_H = 8'h29;

    localparam int BIT_VRA = 0;
    localparam int BIT_DRA = 1;
    localparam int BIT_VRM = 3;

    typedef struct packed {
        logic       store;
        logic [7:0] val;
        logic       cap;
        logic       dac_rst;
    } wr_act_t;

    function automatic logic [7:0] vol_clamp(input logic [7:0] raw, input logic [7:0] keep);
        logic [7:0] v;
        v = raw & keep;
        if (v[5]) v = {v[7:6], 6'h1F};
        return v;
    endfunction

    function automatic logic is_read_only(input logic [7:0] idx);
        return (idx == 8'h00) || (idx == 8'h01) || (idx == IX_STATUS) ||
               (idx == IX_EXT_ID) || (idx == IX_EXT_ID_H);
    endfunction

    function automatic logic [7:0] reset_byte(input logic [7:0] idx, input logic dbl,
                                              input logic [1:0] cid);
        logic [7:0] b;
        b = 8'h00;
        if (idx == IX_STATUS)        b = 8'h0F;
        else if (idx == IX_EXT_ID)   b = dbl ? 8'h0B : 8'h09;
        else if (idx == IX_EXT_ID_H) b = {cid, 6'h02};
        else if (idx >= IX_RATE_LO && idx <= IX_RATE_HI)
            b = idx[0] ? RATE_MAX[15:8] : RATE_MAX[7:0];
        return b;
    endfunction

endpackage

// File: rtl/acr_wr_filter.sv
module acr_wr_filter
    import acr_pkg::*;
#(
    parameter bit DOUBLE_RATE = 1'b1
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       data,
    input  logic             vra,
    input  logic             vrm,
    input  logic [7:0]       partner_lo,
    output wr_act_t          act
);
    localparam logic [7:0] CTL_KEEP = DOUBLE_RATE ? 8'h0B : 8'h09;

    logic gate;

    always_comb begin
        act  = '{store: 1'b1, val: data, cap: 1'b0, dac_rst: 1'b0};
        gate = (idx < IX_ADC_LO) ? vra : vrm;
        if (is_read_only(idx)) begin
            act.store = 1'b0;
        end else begin
            case (idx)
                8'h02, 8'h04, 8'h06: act.val = vol_clamp(data, 8'h3F);
                8'h03, 8'h05:        act.val = vol_clamp(data, 8'hBF);
                8'h0A:               act.val = data & 8'h1E;
                IX_CTL: begin
                    act.val     = data & CTL_KEEP;
                    act.dac_rst = ~data[BIT_VRA];
                end
                default: begin
                    if (idx >= IX_RATE_LO && idx <= IX_RATE_HI) begin
                        if (!gate) begin
                            act.store = 1'b0;
                        end else if (idx[0] && ({data, partner_lo} > RATE_MAX)) begin
                            act.store = 1'b0;
                            act.cap   = 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/acr_store.sv
module acr_store
    import acr_pkg::*;
#(
    parameter bit       DOUBLE_RATE = 1'b1,
    parameter bit [1:0] CODEC_ID    = 2'd0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  wr_act_t                      act,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [7:0]                   rd_data,
    output logic [7:0]                   partner_lo,
    output logic [7:0]                   ctl_q,
    output logic [NUM_RATES-1:0][15:0]   rates_q
);
    logic [7:0] mem [DEPTH];
    logic [IDX_W-1:0] pair_lo;

    assign pair_lo    = {wr_idx[IDX_W-1:1], 1'b0};
    assign partner_lo = mem[pair_lo];
    assign ctl_q      = mem[IX_CTL];

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        localparam logic [IDX_W-1:0] LO = IX_RATE_LO + IDX_W'(2 * g);
        assign rates_q[g] = {mem[LO + 1'b1], mem[LO]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= reset_byte(IDX_W'(i), DOUBLE_RATE, CODEC_ID);
            rd_data <= '0;
        end else begin
            rd_data <= mem[rd_idx];
            if (wr_en) begin
                if (act.store) mem[wr_idx] <= act.val;
                if (act.cap) begin
                    mem[pair_lo] <= RATE_MAX[7:0];
                    mem[wr_idx]  <= RATE_MAX[15:8];
                end
                if (act.dac_rst) begin
                    for (int k = 0; k < NUM_DAC; k++) begin
                        mem[IX_RATE_LO + IDX_W'(2 * k)]      <= RATE_MAX[7:0];
                        mem[IX_RATE_LO + IDX_W'(2 * k + 1)]  <= RATE_MAX[15:8];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/acr_rate_view.sv
module acr_rate_view
    import acr_pkg::*;
(
    input  logic [NUM_RATES-1:0][15:0] rates,
    input  logic                       dra,
    input  logic [SEL_W-1:0]           sel,
    output logic [RATE_OUT_W-1:0]      eff
);
    always_comb begin
        eff = '0;
        for (int k = 0; k < NUM_RATES; k++) begin
            if (SEL_W'(k) == sel)
                eff = (k < NUM_DAC && dra) ? {rates[k], 1'b0} : {1'b0, rates[k]};
        end
    end
endmodule

// File: rtl/acodec_regfile.sv
module acodec_regfile
    import acr_pkg::*;
#(
    parameter bit       DOUBLE_RATE = 1'b1,
    parameter bit [1:0] CODEC_ID    = 2'd0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    input  logic [SEL_W-1:0]      rate_sel,
    output logic [RATE_OUT_W-1:0] rate_out
);
    wr_act_t                    act;
    logic [7:0]                 partner_lo;
    logic [7:0]                 ctl_q;
    logic [NUM_RATES-1:0][15:0] rates_q;

    acr_wr_filter #(.DOUBLE_RATE(DOUBLE_RATE)) u_filter (
        .idx        (wr_idx),
        .data       (wr_data),
        .vra        (ctl_q[BIT_VRA]),
        .vrm        (ctl_q[BIT_VRM]),
        .partner_lo (partner_lo),
        .act        (act)
    );

    acr_store #(.DOUBLE_RATE(DOUBLE_RATE), .CODEC_ID(CODEC_ID)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .act        (act),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .partner_lo (partner_lo),
        .ctl_q      (ctl_q),
        .rates_q    (rates_q)
    );

    acr_rate_view u_view (
        .rates (rates_q),
        .dra   (ctl_q[BIT_DRA]),
        .sel   (rate_sel),
        .eff   (rate_out)
    );

endmodule

// File: rtl/acodec_regfile_chk.sv
module acodec_regfile_chk
    import acr_pkg::*;
#(
    parameter bit DOUBLE_RATE = 1'b1
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       wr_en,
    input logic [IDX_W-1:0]           wr_idx,
    input logic [7:0]                 wr_data,
    input logic [SEL_W-1:0]           rate_sel,
    input logic [RATE_OUT_W-1:0]      rate_out,
    input logic [7:0]                 ctl_q,
    input logic [NUM_RATES-1:0][15:0] rates_q
);
    localparam logic [7:0] CTL_KEEP = DOUBLE_RATE ? 8'h0B : 8'h09;

    p_ctl_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl_q & ~CTL_KEEP) == 8'h00);

    p_dac_reset_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IX_CTL && !wr_data[BIT_VRA]) |=>
        (rates_q[0] == RATE_MAX && rates_q[1] == RATE_MAX && rates_q[2] == RATE_MAX));

    p_dac_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx >= IX_RATE_LO && wr_idx < IX_ADC_LO && !ctl_q[BIT_VRA]) |=>
        $stable(rates_q));

    p_adc_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx >= IX_ADC_LO && wr_idx <= IX_RATE_HI && !ctl_q[BIT_VRM]) |=>
        $stable(rates_q));

    p_rate_cap_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == 8'h2D && ctl_q[BIT_VRA] &&
         ({wr_data, rates_q[0][7:0]} > RATE_MAX)) |=> (rates_q[0] == RATE_MAX));

    p_dac_double_r9: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == 3'd0 && ctl_q[BIT_DRA]) |-> (rate_out == {rates_q[0], 1'b0}));

    p_adc_single_r9: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == 3'd3) |-> (rate_out == {1'b0, rates_q[3]}));

endmodule

bind acodec_regfile acodec_regfile_chk #(.DOUBLE_RATE(DOUBLE_RATE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rate_sel (rate_sel),
    .rate_out (rate_out),
    .ctl_q    (ctl_q),
    .rates_q  (rates_q)
);

// File: tb/tb_acodec_regfile.sv
module tb_acodec_regfile;

    localparam bit       DR  = 1'b1;
    localparam bit [1:0] CID = 2'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_idx = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_idx = '0;
    logic [7:0]  rd_data;
    logic [2:0]  rate_sel = '0;
    logic [16:0] rate_out;

    int checks = 0;
    int fails  = 0;
    int m [256];

    always #10 clk = ~clk;

    acodec_regfile #(.DOUBLE_RATE(DR), .CODEC_ID(CID)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .rate_sel(rate_sel), .rate_out(rate_out)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    function automatic int sat_level(input int v);
        if ((v & 32) != 0) return (v - 32) | 31;
        return v;
    endfunction

    task automatic model_reset();
        foreach (m[i]) m[i] = 0;
        m['h26] = 15;
        m['h28] = DR ? 11 : 9;
        m['h29] = CID * 64 + 2;
        for (int r = 0; r < 5; r++) begin
            m['h2C + 2 * r] = 48000 % 256;
            m['h2D + 2 * r] = 48000 / 256;
        end
    endtask

    task automatic model_write(input int a, input int d);
        int ok;
        if (a == 0 || a == 1 || a == 'h26 || a == 'h28 || a == 'h29) return;
        if (a == 2 || a == 4 || a == 6) m[a] = sat_level(d & 'h3F);
        else if (a == 3 || a == 5) m[a] = sat_level(d & 'hBF);
        else if (a == 'h0A) m[a] = d & 'h1E;
        else if (a == 'h2A) begin
            m[a] = d & (DR ? 'h0B : 'h09);
            if ((m[a] & 1) == 0)
                for (int r = 0; r < 3; r++) begin
                    m['h2C + 2 * r] = 48000 % 256;
                    m['h2D + 2 * r] = 48000 / 256;
                end
        end else if (a >= 'h2C && a <= 'h35) begin
            ok = (a < 'h32) ? (m['h2A] & 1) : ((m['h2A] >> 3) & 1);
            if (ok == 0) return;
            if ((a % 2) == 1 && (d * 256 + m[a - 1]) > 48000) begin
                m[a - 1] = 48000 % 256;
                m[a]     = 48000 / 256;
            end else m[a] = d;
        end else m[a] = d;
    endtask

    function automatic int model_rate(input int s);
        int v;
        if (s > 4) return 0;
        v = m['h2C + 2 * s] + 256 * m['h2D + 2 * s];
        if (s < 3 && (m['h2A] & 2) != 0) v = v * 2;
        return v;
    endfunction

    task automatic step(input bit we, input int a, input int d, input int ra,
                        input int rs, input string tag);
        int exp_rd;
        @(negedge clk);
        wr_en = we; wr_idx = a[7:0]; wr_data = d[7:0]; rd_idx = ra[7:0]; rate_sel = rs[2:0];
        @(posedge clk);
        exp_rd = m[ra];
        if (we) model_write(a, d);
        @(negedge clk);
        check(32'(rd_data), exp_rd, tag);
        check(32'(rate_out), model_rate(rs), {tag, "/R9"});
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input int rs, input string tag);
        step(1'b0, 0, 0, a, rs, tag);
    endtask

    task automatic wr(input int a, input int d, input string tag);
        step(1'b1, a, d, a, 0, tag);
        rd(a, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(32'(rd_data), 0, "R1 rd_data in reset");
        rst = 1'b0;

        // R1 and R12: defaults and byte order of rates
        foreach (m[i]) if (i < 'h40) rd(i, 0, "R1");
        rd('h2C, 3, "R12 low byte");
        rd('h2D, 4, "R12 high byte");

        // R2 volume low bytes
        wr('h02, 'hFF, "R2");
        wr('h02, 'h15, "R2");
        wr('h04, 'hC0, "R2");
        wr('h06, 'h3A, "R2");
        // R3 volume high bytes
        wr('h03, 'hFF, "R3");
        wr('h03, 'h60, "R3");
        wr('h05, 'hC5, "R3");
        wr('h05, 'h1C, "R3");
        // R4 beep
        wr('h0A, 'hFF, "R4");
        // R10 read-only indices
        wr('h28, 'hFF, "R10");
        wr('h29, 'h00, "R10");
        wr('h26, 'h00, "R10");
        wr('h00, 'h55, "R10");
        // R11 plain storage and read-before-write
        step(1'b1, 'h10, 'hA5, 'h10, 0, "R11 old value");
        rd('h10, 0, "R11 new value");
        wr('h7F, 'h3C, "R11");

        // R7 gated while enables are off
        wr('h2C, 'h11, "R7 DAC gated");
        wr('h33, 'h11, "R7 ADC gated");

        // R5 control mask, enable all
        wr('h2A, 'hFF, "R5");
        rd('h2A, 0, "R9 doubled DAC");
        // R12 / R8 accepted writes
        wr('h2C, 'h44, "R12");
        wr('h2D, 'hAC, "R12");
        rd('h2C, 0, "R9 44100 doubled");
        wr('h32, 'h40, "R7 ADC open");
        wr('h33, 'h1F, "R7 ADC open");
        rd('h32, 3, "R9 ADC not doubled");
        // R8 cap above, exactly on limit
        wr('h2E, 'hFF, "R8 low unlimited");
        wr('h2F, 'hBB, "R8 over limit");
        rd('h2E, 1, "R8 capped low byte");
        wr('h30, 'h80, "R8");
        wr('h31, 'hBB, "R8 at limit");
        wr('h35, 'hFF, "R8 ADC over limit");
        rd('h34, 4, "R8");

        // R6 VRA off, VRM on
        wr('h2A, 'h08, "R6");
        rd('h2C, 0, "R6 DAC back to 48000");
        rd('h2D, 1, "R6");
        rd('h32, 3, "R6 ADC kept");
        wr('h2C, 'h01, "R7 DAC gated again");
        wr('h34, 'h22, "R7 ADC still open");
        wr('h2A, 'h00, "R6");
        wr('h35, 'h01, "R7 ADC gated");
        rd(0, 6, "R9 sel out of range");

        // R11 mixed pseudo-random traffic
        for (int n = 0; n < 600; n++) begin
            int a;
            a = (n % 5 == 0) ? 'h2A : int'($urandom_range(0, 63));
            step(1'b1, a, int'($urandom_range(0, 255)), int'($urandom_range(0, 63)),
                 int'($urandom_range(0, 7)), "R11 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule